// File: doc/BRIEF.md
# Parallel Channel Upset Monitor

The block drives a constant or alternating test pattern onto a set of parallel channels. Each channel runs through a register chain of fixed depth in the circuit under test and comes back to the monitor. Every cycle the monitor compares the returned bits with the value the pattern had one chain latency earlier. It then sorts the mismatching channels of that cycle into one of three kinds of event: an isolated hit on a single channel, a hit spread over several channels, or a hit that covers every channel of one I/O bank. A fixed channel-to-bank map, given as a parameter, defines the banks.

Each event kind has its own saturating counter. There is also one counter per bank and one per channel. A host reads any counter by placing its index on a read port, and a single strobe clears all counters together. Comparison begins on a start pulse. After that pulse, and after every change of pattern, comparison is held off until the chains have refilled with the new pattern.

Top module: `upset_monitor`

## Requirements
- R1: `stimOut` follows the pattern code that `patSel` held at the previous clock edge: 0 drives all zeros, 1 drives all ones, 2 drives a checkerboard with bit c equal to (c mod 2) XOR phase, and 3 drives the inverse of code 2. The phase is 0 in the first cycle after a `start` pulse and toggles on every cycle after that.
- R2: Once the pattern has been held steady, a returned vector equal to `stimOut` from `LATENCY` cycles earlier produces no count. This holds for the checkerboard codes when `LATENCY` is odd.
- R3: No comparison takes place before the first `start` pulse. After `start`, or after a change of pattern code, the returns sampled at the next `LATENCY` clock edges are ignored. The first edge that compares is edge `LATENCY`+1.
- R4: Counter index 0 counts compare cycles that have exactly one mismatching channel and no complete bank.
- R5: Counter index 1 counts compare cycles that have two or more mismatching channels and no complete bank.
- R6: Counter index 2+b counts compare cycles in which every channel mapped to bank b mismatches. This applies to a bank of one channel as well. In such a cycle neither counter 0 nor counter 1 advances.
- R7: Counter index 2+`NUM_BANKS`+c counts compare cycles in which channel c mismatches, whatever the event kind.
- R8: Each counter stops at 2^`CNT_W`-1 and never wraps around.
- R9: While `cntClear` is high, every counter goes to zero at the next edge. The clear takes priority over any increment in the same cycle.
- R10: `rdData` shows the counter selected by `rdIdx` without delay. Any index at or above 2+`NUM_BANKS`+`NUM_CH` (at most 64 counters) reads as zero.
- R11: After reset, all counters read zero, the pattern code is 0, and the monitor is idle until `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms comparison and restarts the phase |
| patSel | input | 2 | Pattern code |
| cntClear | input | 1 | Synchronous clear of all counters |
| stimOut | output | NUM_CH | Pattern driven into the channels |
| retIn | input | NUM_CH | Bits returned from the channel chains |
| rdIdx | input | 6 | Counter index for readout |
| rdData | output | CNT_W | Selected counter value |

## Verification
The hardest condition to reach from the ports is a mismatch on exactly the first compared edge after a pattern change. Right next to it, the edge before it must still be blanked even though the chain carries stale data. The bench models the chains as shift registers with a one-hot XOR injection on their outputs. It counts negedges from the start pulse to place a single injected error on edge `LATENCY`+1. The stale pattern then acts as a natural all-channel mismatch on the preceding edges, so a blanking window that is one cycle too short or too long shows up in the counters. A small configuration with an odd latency and uneven banks, one of which has a single channel, lets the bench sweep every non-empty mismatch mask.

// File: rtl/umon_pkg.sv
package umon_pkg;

  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    PAT_ZEROS     = 2'd0,
    PAT_ONES      = 2'd1,
    PAT_CHECK     = 2'd2,
    PAT_CHECK_INV = 2'd3
  } pattern_e;

  typedef struct packed {
    pattern_e pat;
    logic     phase;
    logic     compareEn;
    logic     clearCnt;
  } ctrlStrobes_t;

  function automatic logic patBit(pattern_e p, logic ph, logic chOdd);
    case (p)
      PAT_ZEROS:     patBit = 1'b0;
      PAT_ONES:      patBit = 1'b1;
      PAT_CHECK:     patBit = chOdd ^ ph;
      default:       patBit = ~(chOdd ^ ph);
    endcase
  endfunction

endpackage

// File: rtl/umon_ctrl.sv
module umon_ctrl
  import umon_pkg::*;
#(
  parameter int LATENCY = 86
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   patSel,
  input  logic         cntClear,
  output ctrlStrobes_t strobes
);

  localparam int SETTLE_W = $clog2(LATENCY + 1);

  pattern_e              patReg;
  logic                  phase;
  logic                  armed;
  logic [SETTLE_W-1:0]   settle;
  pattern_e              patNext;

  assign patNext = pattern_e'(patSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patReg <= PAT_ZEROS;
      phase  <= 1'b0;
      armed  <= 1'b0;
      settle <= '0;
    end else begin
      patReg <= patNext;
      phase  <= start ? 1'b0 : ~phase;
      if (start) armed <= 1'b1;
      if (start || (patNext != patReg)) begin
        settle <= SETTLE_W'(LATENCY);
      end else if (settle != '0) begin
        settle <= settle - 1'b1;
      end
    end
  end

  always_comb begin
    strobes.pat       = patReg;
    strobes.phase     = phase;
    strobes.compareEn = armed && (settle == '0);
    strobes.clearCnt  = cntClear;
  end

endmodule

// File: rtl/umon_datapath.sv
module umon_datapath
  import umon_pkg::*;
#(
  parameter int NUM_CH    = 28,
  parameter int NUM_BANKS = 2,
  parameter int LATENCY   = 86,
  parameter int CNT_W     = 16,
  parameter logic [NUM_CH*8-1:0] BANK_MAP = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_CH-1:0]  retIn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [NUM_CH-1:0]  stimOut,
  output logic [CNT_W-1:0]   rdData
);

  localparam int   NUM_CNT   = 2 + NUM_BANKS + NUM_CH;
  localparam int   IDX_ISO   = 0;
  localparam int   IDX_MULTI = 1;
  localparam int   IDX_BANK0 = 2;
  localparam int   IDX_CH0   = 2 + NUM_BANKS;
  localparam logic LAT_ODD   = 1'(LATENCY % 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CH-1:0]    expBits;
  logic [NUM_CH-1:0]    mismatch;
  logic [NUM_CH-1:0]    bankMember [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankHit;
  logic                 anyBank;
  int                   hitCount;
  logic                 isoEvt;
  logic                 multiEvt;
  logic [NUM_CNT-1:0]   incr;
  logic [CNT_W-1:0]     cnt [NUM_CNT];

  // stimulus and expected value per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam logic CH_ODD = 1'(c % 2);
    assign stimOut[c] = patBit(strobes.pat, strobes.phase, CH_ODD);
    assign expBits[c] = patBit(strobes.pat, strobes.phase ^ LAT_ODD, CH_ODD);
  end

  assign mismatch = strobes.compareEn ? (retIn ^ expBits) : '0;

  // bank membership from the parameter map
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
        bankMember[b][c] = (BANK_MAP[8*c +: 8] == 8'(b));
      end
    end
    assign bankHit[b] = (|bankMember[b]) &&
                        ((mismatch & bankMember[b]) == bankMember[b]);
  end

  assign anyBank  = |bankHit;
  assign hitCount = $countones(mismatch);
  assign isoEvt   = !anyBank && (hitCount == 1);
  assign multiEvt = !anyBank && (hitCount > 1);

  always_comb begin
    incr            = '0;
    incr[IDX_ISO]   = isoEvt;
    incr[IDX_MULTI] = multiEvt;
    for (int b = 0; b < NUM_BANKS; b++) incr[IDX_BANK0 + b] = bankHit[b];
    for (int c = 0; c < NUM_CH; c++)    incr[IDX_CH0 + c]   = mismatch[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CNT; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (strobes.clearCnt) begin
          cnt[i] <= '0;
        end else if (incr[i] && (cnt[i] != CNT_MAX)) begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rdIdx == IDX_W'(i)) rdData = cnt[i];
    end
  end

endmodule

// File: rtl/upset_monitor.sv
module upset_monitor
  import umon_pkg::*;
#(
  parameter int NUM_CH    = 28,
  parameter int NUM_BANKS = 2,
  parameter int LATENCY   = 86,
  parameter int CNT_W     = 16,
  parameter logic [NUM_CH*8-1:0] BANK_MAP =
    {{(NUM_CH - NUM_CH/2){8'd1}}, {(NUM_CH/2){8'd0}}}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         patSel,
  input  logic               cntClear,
  output logic [NUM_CH-1:0]  stimOut,
  input  logic [NUM_CH-1:0]  retIn,
  input  logic [5:0]         rdIdx,
  output logic [CNT_W-1:0]   rdData
);

  ctrlStrobes_t strobes;

  umon_ctrl #(.LATENCY(LATENCY)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .patSel   (patSel),
    .cntClear (cntClear),
    .strobes  (strobes)
  );

  umon_datapath #(
    .NUM_CH    (NUM_CH),
    .NUM_BANKS (NUM_BANKS),
    .LATENCY   (LATENCY),
    .CNT_W     (CNT_W),
    .BANK_MAP  (BANK_MAP)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .retIn   (retIn),
    .rdIdx   (rdIdx),
    .stimOut (stimOut),
    .rdData  (rdData)
  );

endmodule

// File: rtl/upset_monitor_chk.sv
module upset_monitor_chk
  import umon_pkg::*;
#(
  parameter int NUM_CH    = 28,
  parameter int NUM_BANKS = 2,
  parameter int CNT_W     = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        patSel,
  input logic              cntClear,
  input logic [NUM_CH-1:0] stimOut,
  input logic [5:0]        rdIdx,
  input logic [CNT_W-1:0]  rdData,
  input ctrlStrobes_t      strobes
);

  localparam int NUM_CNT = 2 + NUM_BANKS + NUM_CH;

  assert_zeros_pattern_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(patSel) == 2'd0) |-> stimOut == '0);

  assert_ones_pattern_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(patSel) == 2'd1) |-> stimOut == '1);

  assert_check_toggle_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(patSel) == 2'd2 &&
     $past(patSel, 2) == 2'd2 && !$past(start)) |-> stimOut == ~$past(stimOut));

  assert_blank_on_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && strobes.pat != $past(strobes.pat)) |-> !strobes.compareEn);

  assert_blank_on_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(start)) |-> !strobes.compareEn);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(rdIdx) && !$past(cntClear)) |-> rdData >= $past(rdData));

  assert_hold_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(rdIdx) && !$past(cntClear) && $past(rdData) == '1)
      |-> rdData == '1);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> rdData == '0);

  assert_oob_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rdIdx} >= 7'(NUM_CNT)) |-> rdData == '0);

endmodule

bind upset_monitor upset_monitor_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_BANKS (NUM_BANKS),
  .CNT_W     (CNT_W)
) i_upset_monitor_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .patSel   (patSel),
  .cntClear (cntClear),
  .stimOut  (stimOut),
  .rdIdx    (rdIdx),
  .rdData   (rdData),
  .strobes  (strobes)
);

// File: tb/test_upset_monitor.sv
module test_upset_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 6;
  localparam int NBK   = 3;
  localparam int LAT   = 5;
  localparam int CW    = 8;
  localparam int NCNT  = 2 + NBK + NCH;
  localparam int CMAX  = (1 << CW) - 1;
  localparam logic [NCH*8-1:0] MAP = {8'd2, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [1:0]     patSel = 2'd0;
  logic           cntClear = 1'b0;
  logic [NCH-1:0] stimOut;
  logic [NCH-1:0] retIn;
  logic [NCH-1:0] injMask = '0;
  logic [5:0]     rdIdx = '0;
  logic [CW-1:0]  rdData;
  logic [NCH-1:0] chain [LAT];
  logic           tbPhase;

  int checks = 0;
  int errors = 0;
  int expCnt [NCNT];

  always #(CLK_PERIOD/2) clk = ~clk;

  upset_monitor #(
    .NUM_CH(NCH), .NUM_BANKS(NBK), .LATENCY(LAT), .CNT_W(CW), .BANK_MAP(MAP)
  ) i_upset_monitor (
    .clk(clk), .rstN(rstN), .start(start), .patSel(patSel), .cntClear(cntClear),
    .stimOut(stimOut), .retIn(retIn), .rdIdx(rdIdx), .rdData(rdData)
  );

  // channel chains of the circuit under test, no reset
  always_ff @(posedge clk) begin
    chain[0] <= stimOut;
    for (int k = 1; k < LAT; k++) chain[k] <= chain[k-1];
  end
  assign retIn = chain[LAT-1] ^ injMask;

  always_ff @(posedge clk) begin
    if (!rstN) tbPhase <= 1'b0;
    else       tbPhase <= start ? 1'b0 : ~tbPhase;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bankOf(int c);
    return (c < 3) ? 0 : ((c < 5) ? 1 : 2);
  endfunction

  function automatic void bump(int idx);
    if (expCnt[idx] < CMAX) expCnt[idx]++;
  endfunction

  function automatic void modelHit(logic [NCH-1:0] m);
    int ones = 0;
    logic hit;
    logic anyB = 1'b0;
    for (int b = 0; b < NBK; b++) begin
      hit = 1'b1;
      for (int c = 0; c < NCH; c++) if (bankOf(c) == b && !m[c]) hit = 1'b0;
      if (hit) begin
        anyB = 1'b1;
        bump(2 + b);
      end
    end
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      ones++;
      bump(2 + NBK + c);
    end
    if (!anyB && ones == 1) bump(0);
    if (!anyB && ones > 1)  bump(1);
  endfunction

  function automatic string reqOf(int idx);
    if (idx == 0) return "R4";
    if (idx == 1) return "R5";
    if (idx < 2 + NBK) return "R6";
    return "R7";
  endfunction

  task automatic checkAll(string ctx);
    for (int i = 0; i < NCNT; i++) begin
      rdIdx = 6'(i);
      #1;
      check($sformatf("%s/%s idx%0d", ctx, reqOf(i), i), int'(rdData), expCnt[i]);
    end
    rdIdx = '0;
  endtask

  function automatic logic [NCH-1:0] patExp(int p, logic ph);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) begin
      case (p)
        0: v[c] = 1'b0;
        1: v[c] = 1'b1;
        2: v[c] = 1'(c % 2) ^ ph;
        default: v[c] = ~(1'(c % 2) ^ ph);
      endcase
    end
    return v;
  endfunction

  task automatic inject(logic [NCH-1:0] m);
    @(negedge clk) injMask = m;
    modelHit(m);
    @(negedge clk) injMask = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCNT; i++) expCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    checkAll("R11");
    check("R11 stimOut", int'(stimOut), 0);

    // R3: errors before start are ignored
    @(negedge clk) injMask = '1;
    @(negedge clk) injMask = '0;
    repeat (2) @(negedge clk);
    checkAll("R3 prestart");

    // R3/R1: start with ones, hit exactly the first compared edge
    @(negedge clk) begin patSel = 2'd1; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    check("R1 ones", int'(stimOut), int'(patExp(1, 1'b0)));
    repeat (LAT - 1) @(negedge clk);
    inject(6'b000001);
    @(negedge clk);
    checkAll("R3 window");

    // R1: every pattern code, two phases each
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) patSel = 2'(p);
      @(negedge clk);
      check($sformatf("R1 pat%0d a", p), int'(stimOut), int'(patExp(p, tbPhase)));
      @(negedge clk);
      check($sformatf("R1 pat%0d b", p), int'(stimOut), int'(patExp(p, tbPhase)));
    end

    // R2: checkerboard with odd latency produces no counts
    @(negedge clk) patSel = 2'd2;
    repeat (LAT + 4) @(negedge clk);
    checkAll("R2 check");

    // R4..R7: every non-empty mismatch mask
    for (int m = 1; m < (1 << NCH); m++) inject(NCH'(m));
    checkAll("sweep");

    // R2/R6: inverted checkerboard, single-channel bank
    @(negedge clk) patSel = 2'd3;
    repeat (LAT + 4) @(negedge clk);
    checkAll("R2 inv");
    inject(6'b100000);
    checkAll("R6 lone bank");

    // R9: clear beats a simultaneous increment
    @(negedge clk) begin cntClear = 1'b1; injMask = 6'b000011; end
    @(negedge clk) begin cntClear = 1'b0; injMask = '0; end
    for (int i = 0; i < NCNT; i++) expCnt[i] = 0;
    checkAll("R9");

    // R8: saturation
    @(negedge clk) injMask = 6'b000001;
    for (int k = 0; k < 300; k++) begin
      modelHit(6'b000001);
      @(negedge clk);
    end
    injMask = '0;
    @(negedge clk);
    checkAll("R8");
    check("R8 iso max", int'(expCnt[0]), CMAX);

    // R10: out-of-range indices read zero
    rdIdx = 6'(NCNT);
    #1 check("R10 first unused", int'(rdData), 0);
    rdIdx = 6'd63;
    #1 check("R10 last slot", int'(rdData), 0);
    rdIdx = 6'd0;
    #1 check("R10 in range", int'(rdData), CMAX);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule